// File: doc/BRIEF.md
# ALU Status Flag Generator

This unit performs one of four simple operations (add, subtract, bitwise AND, bitwise XOR) on two operands at a quarter-width, half-width or full-width operand size. From the result it derives six status flags: carry, overflow, sign, zero, auxiliary carry and parity. With the default 32-bit datapath the three sizes are 8, 16 and 32 bits. The result and the flags are kept in registers. They change only on a clock edge where the update enable is high.

A datapath controller drives the operands and the update enable for each operation and reads the registered result and flags on the next cycle. Control software can also set or clear any group of flag bits at once through a bit mask. A masked write wins over an ALU flag update in the same cycle.

Top module: `alu_flag_unit`

## Requirements
- R1: A synchronous active-high reset clears the result register and all six flag bits.
- R2: Operation code 00 adds, 01 subtracts (first minus second), 10 is bitwise AND and 11 is bitwise XOR. Size code 00 selects the low DATA_W/4 bits, 01 the low DATA_W/2 bits, and 10 or 11 the full width. Operand bits above the size are ignored and result bits above it read zero. The result appears one clock edge after a cycle with the update enable high.
- R3: The carry flag (flag bit 0) is set on add when the unsigned sum exceeds the size range, and on subtract when the second operand is larger than the first as unsigned numbers.
- R4: The overflow flag (flag bit 1) is set when the true signed result of an add or subtract lies outside the signed range of the operand size.
- R5: The sign flag (flag bit 2) equals the top result bit at the operand size. The zero flag (flag bit 3) is set when every result bit at the operand size is zero.
- R6: The auxiliary flag (flag bit 4) is set on add when the low nibbles produce a carry into bit 4, and on subtract when the low nibble of the second operand is larger than that of the first.
- R7: The parity flag (flag bit 5) is set when the lowest result byte holds an even number of 1 bits, at every operand size.
- R8: For AND and XOR, carry, overflow and auxiliary are cleared. Sign, zero and parity follow the result.
- R9: On an edge with the update enable low and a zero write mask, the result and the flags hold.
- R10: On an edge with a non-zero write mask, each masked flag bit takes the write data bit and each unmasked bit keeps its value. No ALU flag update happens on that edge, but the result still loads if the update enable is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_a | input | DATA_W | First operand |
| op_b | input | DATA_W | Second operand |
| op_sel | input | 2 | Operation code |
| size_sel | input | 2 | Operand size code |
| upd_en | input | 1 | Load result and ALU flags on this edge |
| flag_wr_mask | input | 6 | Flag bits to overwrite directly |
| flag_wr_data | input | 6 | Values for the masked flag bits |
| result | output | DATA_W | Registered result, zero above operand size |
| flags | output | 6 | Registered flags: bit 0 carry, 1 overflow, 2 sign, 3 zero, 4 auxiliary, 5 parity |

## Verification
The result and every flag are due exactly one edge after the cycle in which they were requested. The bench drives inputs on a falling edge and compares on the next falling edge, after the single register stage has loaded. Hold and masked-write checks apply new operands with the enable low, or together with a mask, and read the flags and the result on that same following falling edge. That way a stray update would already be visible when the check is made.

// File: rtl/alu_flag_pkg.sv
package alu_flag_pkg;

  typedef enum logic [1:0] {
    OP_ADD = 2'b00,
    OP_SUB = 2'b01,
    OP_AND = 2'b10,
    OP_XOR = 2'b11
  } op_e;

  localparam int FLAG_N   = 6;
  localparam int LANE_N   = 3;

  // bit 0 carry ... bit 5 parity (packed MSB first)
  typedef struct packed {
    logic pa;
    logic ax;
    logic zr;
    logic sg;
    logic ov;
    logic cy;
  } flags_t;

endpackage

// File: rtl/alu_flag_lanes.sv
module alu_flag_lanes
  import alu_flag_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  op_e                               op,
  input  logic [DATA_W-1:0]                 a,
  input  logic [DATA_W-1:0]                 b,
  output logic [LANE_N-1:0][DATA_W-1:0]     lane_res,
  output logic [LANE_N-1:0]                 lane_cy,
  output logic [LANE_N-1:0]                 lane_ov,
  output logic [LANE_N-1:0]                 lane_sg,
  output logic [LANE_N-1:0]                 lane_zr
);

  logic is_arith;
  assign is_arith = (op == OP_ADD) || (op == OP_SUB);

  // one lane per operand size: quarter, half, full width
  for (genvar g = 0; g < LANE_N; g++) begin : g_lane
    localparam int LW = DATA_W >> (LANE_N - 1 - g);
    logic [LW-1:0] la, lb, lr;
    logic [LW:0]   ext;
    logic          ov_add, ov_sub;

    assign la = a[LW-1:0];
    assign lb = b[LW-1:0];

    always_comb begin
      unique case (op)
        OP_ADD:  ext = {1'b0, la} + {1'b0, lb};
        OP_SUB:  ext = {1'b0, la} - {1'b0, lb};
        OP_AND:  ext = {1'b0, la & lb};
        default: ext = {1'b0, la ^ lb};
      endcase
    end

    assign lr     = ext[LW-1:0];
    assign ov_add = (la[LW-1] == lb[LW-1]) && (lr[LW-1] != la[LW-1]);
    assign ov_sub = (la[LW-1] != lb[LW-1]) && (lr[LW-1] != la[LW-1]);

    assign lane_res[g] = DATA_W'(lr);
    assign lane_cy[g]  = is_arith && ext[LW];
    assign lane_ov[g]  = (op == OP_ADD) ? ov_add :
                         (op == OP_SUB) ? ov_sub : 1'b0;
    assign lane_sg[g]  = lr[LW-1];
    assign lane_zr[g]  = (lr == '0);
  end

endmodule

// File: rtl/alu_flag_eval.sv
module alu_flag_eval
  import alu_flag_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic                           clk,
  input  logic                           rst,
  input  op_e                            op,
  input  logic [1:0]                     size_sel,
  input  logic [DATA_W-1:0]              a,
  input  logic [DATA_W-1:0]              b,
  input  logic [LANE_N-1:0][DATA_W-1:0]  lane_res,
  input  logic [LANE_N-1:0]              lane_cy,
  input  logic [LANE_N-1:0]              lane_ov,
  input  logic [LANE_N-1:0]              lane_sg,
  input  logic [LANE_N-1:0]              lane_zr,
  output logic [DATA_W-1:0]              res_next,
  output flags_t                         flg_next
);

  localparam int QW = DATA_W / 4;

  logic [1:0] idx;
  logic       is_arith;

  assign idx      = (size_sel == 2'b00) ? 2'd0 :
                    (size_sel == 2'b01) ? 2'd1 : 2'd2;
  assign is_arith = (op == OP_ADD) || (op == OP_SUB);
  assign res_next = lane_res[idx];

  always_comb begin
    flg_next.cy = lane_cy[idx];
    flg_next.ov = lane_ov[idx];
    flg_next.sg = lane_sg[idx];
    flg_next.zr = lane_zr[idx];
    flg_next.ax = is_arith && (a[4] ^ b[4] ^ res_next[4]);
    flg_next.pa = ~^res_next[7:0];
  end

  AST_LOGIC_CLEARS: assert property (@(posedge clk) disable iff (rst)
    !is_arith |-> !flg_next.cy && !flg_next.ov && !flg_next.ax); // R8
  AST_ZERO_NOT_NEG: assert property (@(posedge clk) disable iff (rst)
    flg_next.zr |-> !flg_next.sg); // R5
  AST_UPPER_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (size_sel == 2'b00) |-> (res_next[DATA_W-1:QW] == '0)); // R2

endmodule

// File: rtl/alu_flag_regs.sv
module alu_flag_regs
  import alu_flag_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              upd_en,
  input  logic [FLAG_N-1:0] wr_mask,
  input  logic [FLAG_N-1:0] wr_data,
  input  logic [DATA_W-1:0] res_next,
  input  flags_t            flg_next,
  output logic [DATA_W-1:0] result_q,
  output logic [FLAG_N-1:0] flags_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      result_q <= '0;
      flags_q  <= '0;
    end else begin
      if (upd_en) result_q <= res_next;
      if (|wr_mask)    flags_q <= (flags_q & ~wr_mask) | (wr_data & wr_mask);
      else if (upd_en) flags_q <= flg_next;
    end
  end

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    (!upd_en && wr_mask == '0) |=> $stable(flags_q) && $stable(result_q)); // R9
  AST_WRITE_TAKES: assert property (@(posedge clk) disable iff (rst)
    (|wr_mask) |=> ((flags_q ^ $past(wr_data)) & $past(wr_mask)) == '0); // R10
  AST_WRITE_KEEPS: assert property (@(posedge clk) disable iff (rst)
    (|wr_mask) |=> ((flags_q ^ $past(flags_q)) & ~$past(wr_mask)) == '0); // R10

endmodule

// File: rtl/alu_flag_unit.sv
module alu_flag_unit
  import alu_flag_pkg::*;
#(
  parameter int DATA_W = 32  // multiple of 4, at least 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] op_a,
  input  logic [DATA_W-1:0] op_b,
  input  logic [1:0]        op_sel,
  input  logic [1:0]        size_sel,
  input  logic              upd_en,
  input  logic [5:0]        flag_wr_mask,
  input  logic [5:0]        flag_wr_data,
  output logic [DATA_W-1:0] result,
  output logic [5:0]        flags
);

  op_e                            op;
  logic [LANE_N-1:0][DATA_W-1:0]  lane_res;
  logic [LANE_N-1:0]              lane_cy, lane_ov, lane_sg, lane_zr;
  logic [DATA_W-1:0]              res_next;
  flags_t                         flg_next;

  assign op = op_e'(op_sel);

  alu_flag_lanes #(.DATA_W(DATA_W)) u_lanes (
    .op(op), .a(op_a), .b(op_b),
    .lane_res(lane_res), .lane_cy(lane_cy), .lane_ov(lane_ov),
    .lane_sg(lane_sg), .lane_zr(lane_zr)
  );

  alu_flag_eval #(.DATA_W(DATA_W)) u_eval (
    .clk(clk), .rst(rst), .op(op), .size_sel(size_sel),
    .a(op_a), .b(op_b),
    .lane_res(lane_res), .lane_cy(lane_cy), .lane_ov(lane_ov),
    .lane_sg(lane_sg), .lane_zr(lane_zr),
    .res_next(res_next), .flg_next(flg_next)
  );

  alu_flag_regs #(.DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst(rst), .upd_en(upd_en),
    .wr_mask(flag_wr_mask), .wr_data(flag_wr_data),
    .res_next(res_next), .flg_next(flg_next),
    .result_q(result), .flags_q(flags)
  );

  AST_PARITY_LOW_BYTE: assert property (@(posedge clk) disable iff (rst)
    (upd_en && flag_wr_mask == '0) |=> flags[5] == ~^result[7:0]); // R7

endmodule

// File: tb/alu_flag_unit_bench.sv
`timescale 1ns/100ps
module alu_flag_unit_bench;

  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst;
  logic [DW-1:0] op_a, op_b;
  logic [1:0]    op_sel, size_sel;
  logic          upd_en;
  logic [5:0]    flag_wr_mask, flag_wr_data;
  logic [DW-1:0] result;
  logic [5:0]    flags;

  int total = 0;
  int bad   = 0;
  bit done  = 0;
  logic [31:0] seed = 32'h1234_5678;

  always #2.5 clk = ~clk;

  alu_flag_unit #(.DATA_W(DW)) u_alu_flag_unit (
    .clk(clk), .rst(rst), .op_a(op_a), .op_b(op_b), .op_sel(op_sel),
    .size_sel(size_sel), .upd_en(upd_en), .flag_wr_mask(flag_wr_mask),
    .flag_wr_data(flag_wr_data), .result(result), .flags(flags)
  );

  task automatic chk(input string tag, input longint unsigned act, input longint unsigned exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] rnd();
    seed = seed * 32'd1664525 + 32'd1013904223;
    return seed;
  endfunction

  // arithmetic reference model built from the requirement text
  task automatic model(input logic [31:0] a, input logic [31:0] b, input int op, input int sz,
                       output logic [31:0] r, output logic [5:0] f);
    int n;
    longint unsigned m, ua, ub, rr;
    longint sa, sb, sr, hi, lo;
    logic cy, ov, ax;
    n  = (sz == 0) ? 8 : (sz == 1) ? 16 : 32;
    m  = (64'd1 << n) - 1;
    ua = a & m;
    ub = b & m;
    hi = (64'sd1 <<< (n - 1)) - 1;
    lo = -(64'sd1 <<< (n - 1));
    sa = (ua > longint'(hi)) ? longint'(ua) - (64'sd1 <<< n) : longint'(ua);
    sb = (ub > longint'(hi)) ? longint'(ub) - (64'sd1 <<< n) : longint'(ub);
    cy = 0; ov = 0; ax = 0;
    case (op)
      0: begin rr = ua + ub; cy = rr > m; ax = ((ua & 15) + (ub & 15)) > 15;
               sr = sa + sb; ov = (sr > hi) || (sr < lo); end
      1: begin rr = ua - ub; cy = ua < ub; ax = (ua & 15) < (ub & 15);
               sr = sa - sb; ov = (sr > hi) || (sr < lo); end
      2: rr = ua & ub;
      default: rr = ua ^ ub;
    endcase
    rr = rr & m;
    r  = rr[31:0];
    f[0] = cy;
    f[1] = ov;
    f[2] = rr[n-1];
    f[3] = (rr == 0);
    f[4] = ax;
    f[5] = ($countones(rr[7:0]) % 2) == 0;
  endtask

  task automatic run_op(input logic [31:0] a, input logic [31:0] b, input int op, input int sz);
    logic [31:0] er;
    logic [5:0]  ef;
    @(negedge clk);
    op_a = a; op_b = b; op_sel = 2'(op); size_sel = 2'(sz);
    upd_en = 1'b1; flag_wr_mask = '0;
    model(a, b, op, sz, er, ef);
    @(negedge clk);
    upd_en = 1'b0;
    chk("R2 result", result, er);
    if (op < 2) begin
      chk("R3 carry", flags[0], ef[0]);
      chk("R4 overflow", flags[1], ef[1]);
      chk("R6 aux", flags[4], ef[4]);
    end else begin
      chk("R8 logic cy/ov/ax", {flags[4], flags[1], flags[0]}, 3'b000);
    end
    chk("R5 sign", flags[2], ef[2]);
    chk("R5 zero", flags[3], ef[3]);
    chk("R7 parity", flags[5], ef[5]);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; op_a = '0; op_b = '0; op_sel = '0; size_sel = '0;
    upd_en = 1'b0; flag_wr_mask = '0; flag_wr_data = '0;
    @(negedge clk);
    op_a = 32'hFFFF_FFFF; op_b = 32'h1; upd_en = 1'b1; flag_wr_mask = 6'h3F; flag_wr_data = 6'h3F;
    @(negedge clk);
    @(negedge clk);
    chk("R1 reset result", result, 0);
    chk("R1 reset flags", flags, 0);
    upd_en = 1'b0; flag_wr_mask = '0; rst = 1'b0;

    // corner values at each size
    run_op(32'h0000_007F, 32'h0000_0001, 0, 0);   // 8-bit signed overflow
    run_op(32'h0000_0080, 32'h0000_0001, 1, 0);   // 8-bit signed overflow on subtract
    run_op(32'hABCD_00FF, 32'h1234_0001, 0, 0);   // carry, zero, upper ignored
    run_op(32'h0000_8000, 32'h0000_8000, 0, 1);
    run_op(32'h7FFF_FFFF, 32'h0000_0001, 0, 2);
    run_op(32'h0000_0000, 32'h0000_0001, 1, 2);   // borrow
    run_op(32'h8000_0000, 32'h0000_0001, 1, 3);   // size code 11 = full
    run_op(32'h0000_0000, 32'h0000_0000, 3, 1);

    // exhaustive first operand at the quarter size
    for (int a = 0; a < 256; a++)
      for (int b = 0; b < 256; b += 17)
        for (int op = 0; op < 4; op++)
          run_op(rnd() & 32'hFFFF_FF00 | 32'(a), rnd() & 32'hFFFF_FF00 | 32'(b), op, 0);

    // pseudo-random sweeps at half and full size
    for (int i = 0; i < 1500; i++)
      for (int op = 0; op < 4; op++) begin
        run_op(rnd(), rnd(), op, 1);
        run_op(rnd(), rnd(), op, 2 + (i & 1));
      end

    // R9 hold: new inputs with enable low
    run_op(32'h0000_0010, 32'h0000_0010, 1, 0);   // zero result, zf=1, pf=1
    @(negedge clk);
    op_a = 32'h0000_00FF; op_b = 32'h0000_0001; op_sel = 2'b00; size_sel = 2'b00;
    upd_en = 1'b0; flag_wr_mask = '0;
    @(negedge clk);
    chk("R9 hold result", result, 0);
    chk("R9 hold flags", flags, 6'b101000);

    // R10 masked write alone: set carry and aux, others keep
    flag_wr_mask = 6'b010001; flag_wr_data = 6'b111111;
    @(negedge clk);
    flag_wr_mask = '0;
    chk("R10 write set", flags, 6'b111001);
    // clear zero only
    flag_wr_mask = 6'b001000; flag_wr_data = 6'b000000;
    @(negedge clk);
    flag_wr_mask = '0;
    chk("R10 write clear", flags, 6'b110001);

    // R10 write wins over an update on the same edge; result still loads
    op_a = 32'h0000_0001; op_b = 32'h0000_0002; op_sel = 2'b00; size_sel = 2'b00;
    upd_en = 1'b1; flag_wr_mask = 6'b000010; flag_wr_data = 6'b000010;
    @(negedge clk);
    upd_en = 1'b0; flag_wr_mask = '0;
    chk("R10 priority flags", flags, 6'b110011);
    chk("R10 priority result", result, 3);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule